// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes a three-wire stereo PCM stream (bit clock, frame clock and serial data) and turns it into parallel samples. For each stereo pair it delivers one left and one right word, each 24 bits wide, together with a single-cycle valid strobe. The external clocks are slower than the local system clock, so they are oversampled. The bit clock and frame clock pass through two-flop synchronisers, and the data bit is captured on each rising edge of the synchronised bit clock.

The block handles two framings. In MSB-first right-justified framing, the word ends on the last bit clock before the frame clock toggles. In I2S framing, the MSB comes one bit clock after the toggle. The format, the word length and the frame-clock polarity come from software control inputs. When the hardware-mode strap is set, two pins select the format and word length instead, and the software inputs are ignored. A right-justified half-frame that is exactly 16 bit clocks long is taken as packed 16-bit data, whatever word length has been programmed. Words shorter than 24 bits are left-aligned, and the unused low bits are filled with zeros.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted, and after reset is released, `left_word` and `right_word` read zero and `pair_valid` is low until the first complete pair has been received.
- R2: In right-justified framing, bits are sampled on rising bit-clock edges MSB first. The word is the last N bits before the frame-clock toggle, and any extra bit clocks at the start of the half-frame are ignored.
- R3: In I2S framing, the bit at the toggle edge is skipped. The next 24 bits fill the word MSB first, later bits are ignored, and bits not received before the next toggle read as zero. The word-length setting has no effect in this framing.
- R4: In software mode, `sw_wlen` sets the right-justified word length: 00 is 16 bits, 01 is 20, 10 is 24 and 11 is 18. `sw_i2s`=1 selects I2S framing.
- R5: In hardware mode (`hw_mode`=1), `hw_sel` selects 00 = 16-bit right-justified, 01 = 20-bit right-justified, 10 = 24-bit right-justified, 11 = I2S. In this mode `sw_i2s`, `sw_wlen` and `sw_lr_swap` have no effect.
- R6: With the polarity swap off, frame clock high carries the left channel. With `sw_lr_swap`=1 in software mode, frame clock low carries the left channel.
- R7: In right-justified framing, a half-frame of exactly 16 bit clocks (a 32-clock frame) is decoded as 16-bit data, whatever word length is programmed.
- R8: A word of N<24 bits is delivered in bits 23 down to 24-N, and the lower bits are zero.
- R9: Exactly one single-cycle `pair_valid` pulse is issued for each left half-frame followed by a right half-frame. The output words change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame (channel select) clock |
| sdata_in | input | 1 | Serial audio data |
| hw_mode | input | 1 | 1: format taken from `hw_sel` pins |
| hw_sel | input | 2 | Hardware format/length select |
| sw_i2s | input | 1 | Software format: 0 right-justified, 1 I2S |
| sw_wlen | input | 2 | Software word-length code |
| sw_lr_swap | input | 1 | Software frame-clock polarity swap |
| left_word | output | 24 | Left sample, left-aligned |
| right_word | output | 24 | Right sample, left-aligned |
| pair_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
The assertions check the following on every cycle: the valid strobe is a single-cycle pulse, the output words hold steady between strobes, the low bits are zero for the 16-, 18- and 20-bit settings, and the outputs are cleared under reset. Only the bench scenarios can show the bit-exact values. These cover the two framings with padding, the skipped I2S delay bit, truncated I2S halves, the packed-frame override, the channel swap, and the hardware pins overriding conflicting software settings. The scoreboard also confirms that no pair is dropped or duplicated.

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int DW    = 24,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_in,
  input  logic          fclk_in,
  input  logic          sdata_in,
  input  logic          hw_mode,
  input  logic [1:0]    hw_sel,
  input  logic          sw_i2s,
  input  logic [1:0]    sw_wlen,
  input  logic          sw_lr_swap,
  output logic [DW-1:0] left_word,
  output logic [DW-1:0] right_word,
  output logic          pair_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] PACKED_LEN = CNT_W'(16);

  logic [1:0] bclk_s, fclk_s, sdat_s;
  logic       bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s <= '0;
      fclk_s <= '0;
      sdat_s <= '0;
      bclk_d <= 1'b0;
    end else begin
      bclk_s <= {bclk_s[0], bclk_in};
      fclk_s <= {fclk_s[0], fclk_in};
      sdat_s <= {sdat_s[0], sdata_in};
      bclk_d <= bclk_s[1];
    end
  end

  logic             rise, fbit, dbit;
  logic             seen, in_half, fprev, left_ok;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    sr, acc, left_hold, rj_word, word;
  logic             is_i2s, swap, edge_now, prev_left;
  logic [4:0]       wl_sel, wl;

  assign rise = bclk_s[1] & ~bclk_d;
  assign fbit = fclk_s[1];
  assign dbit = sdat_s[1];

  always_comb begin
    is_i2s = hw_mode ? (hw_sel == 2'b11) : sw_i2s;
    swap   = hw_mode ? 1'b0 : sw_lr_swap;
    if (hw_mode) begin
      case (hw_sel)
        2'b00:   wl_sel = 5'd16;
        2'b01:   wl_sel = 5'd20;
        default: wl_sel = 5'd24;
      endcase
    end else begin
      case (sw_wlen)
        2'b00:   wl_sel = 5'd16;
        2'b01:   wl_sel = 5'd20;
        2'b10:   wl_sel = 5'd24;
        default: wl_sel = 5'd18;
      endcase
    end
  end

  assign wl        = (cnt == PACKED_LEN) ? 5'd16 : wl_sel;
  assign rj_word   = sr << (DW - int'(wl));
  assign word      = is_i2s ? acc : rj_word;
  assign edge_now  = rise & seen & (fbit != fprev);
  assign prev_left = fprev ^ swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      in_half    <= 1'b0;
      fprev      <= 1'b0;
      left_ok    <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      acc        <= '0;
      left_hold  <= '0;
      left_word  <= '0;
      right_word <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (rise) begin
        seen  <= 1'b1;
        fprev <= fbit;
        sr    <= {sr[DW-2:0], dbit};
        if (edge_now) begin
          cnt     <= CNT_W'(1);
          acc     <= '0;
          in_half <= 1'b1;
          if (in_half) begin
            if (prev_left) begin
              left_hold <= word;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              left_word  <= left_hold;
              right_word <= word;
              pair_valid <= 1'b1;
              left_ok    <= 1'b0;
            end
          end
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          for (int i = 0; i < DW; i++)
            if (in_half && cnt == CNT_W'(DW - i)) acc[i] <= dbit;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hw_mode,
  input logic [1:0]  hw_sel,
  input logic        sw_i2s,
  input logic [1:0]  sw_wlen,
  input logic [23:0] left_word,
  input logic [23:0] right_word,
  input logic        pair_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!pair_valid && left_word == '0 && right_word == '0));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_word) && $stable(right_word)));

  // R5
  hw16_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && hw_mode && hw_sel == 2'b00) |-> (left_word[7:0] == '0 && right_word[7:0] == '0));

  // R8
  hw20_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && hw_mode && hw_sel == 2'b01) |-> (left_word[3:0] == '0 && right_word[3:0] == '0));

  // R4
  sw18_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !hw_mode && !sw_i2s && sw_wlen == 2'b11) |-> (left_word[5:0] == '0 && right_word[5:0] == '0));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .hw_sel(hw_sel),
  .sw_i2s(sw_i2s), .sw_wlen(sw_wlen), .left_word(left_word),
  .right_word(right_word), .pair_valid(pair_valid)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, bclk = 1'b0, fclk = 1'b0, sdat = 1'b0;
  logic hw_mode = 1'b0, sw_i2s = 1'b0, sw_lr_swap = 1'b0;
  logic [1:0] hw_sel = 2'b00, sw_wlen = 2'b00;
  logic [23:0] left_word, right_word;
  logic pair_valid;

  pcm_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fclk_in(fclk), .sdata_in(sdat),
    .hw_mode(hw_mode), .hw_sel(hw_sel), .sw_i2s(sw_i2s), .sw_wlen(sw_wlen),
    .sw_lr_swap(sw_lr_swap), .left_word(left_word), .right_word(right_word),
    .pair_valid(pair_valid)
  );

  int checks = 0, errors = 0;
  logic [23:0] ql[$], qr[$];
  string qt[$];
  logic [23:0] el, er;
  string et;

  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      checks++;
      if (ql.size() == 0) begin
        errors++;
        $display("FAIL R9 extra pair: actual l=%h r=%h expected none", left_word, right_word);
      end else begin
        el = ql.pop_front(); er = qr.pop_front(); et = qt.pop_front();
        if (left_word !== el || right_word !== er) begin
          errors++;
          $display("FAIL %s: actual l=%h r=%h expected l=%h r=%h", et, left_word, right_word, el, er);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic bit_out(input logic lv, input logic b);
    @(negedge clk); fclk = lv; sdat = b;
    repeat (4) @(negedge clk); bclk = 1'b1;
    repeat (4) @(negedge clk); bclk = 1'b0;
  endtask

  function automatic logic [23:0] wmask(int w);
    return (w >= 24) ? 24'hFFFFFF : ((24'h1 << w) - 24'h1);
  endfunction

  function automatic logic [23:0] expect_word(logic [23:0] w, int wlen, int n, bit i2s);
    logic [23:0] v;
    v = (w & wmask(wlen)) << (24 - wlen);
    if (i2s && n - 1 < 24) v = v & ~wmask(24 - (n - 1));
    return v;
  endfunction

  task automatic send_half(input logic lv, input logic [23:0] w, input int wlen, input int n, input bit i2s);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (i2s) begin
        if (i == 0) b = 1'b1;
        else if (i <= wlen) b = w[wlen - i];
        else b = (i > 24);
      end else begin
        if (i >= n - wlen) b = w[wlen - 1 - (i - (n - wlen))];
        else b = 1'b1;
      end
      bit_out(lv, b);
    end
  endtask

  task automatic run_case(input string tag, input bit hw, input logic [1:0] hs, input bit si2s,
                          input logic [1:0] swl, input bit sswap, input int wlen, input int n,
                          input int frames);
    bit i2s;
    logic lvl;
    rst_n = 1'b0;
    hw_mode = hw; hw_sel = hs; sw_i2s = si2s; sw_wlen = swl; sw_lr_swap = sswap;
    bclk = 1'b0; fclk = 1'b0; sdat = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    i2s = hw ? (hs == 2'b11) : si2s;
    lvl = hw ? 1'b1 : !sswap;
    repeat (4) bit_out(!lvl, 1'b0);
    for (int f = 0; f < frames; f++) begin
      logic [23:0] l, r;
      l = 24'($urandom) & wmask(wlen);
      r = 24'($urandom) & wmask(wlen);
      if (f == 0) l = wmask(wlen);
      ql.push_back(expect_word(l, wlen, n, i2s));
      qr.push_back(expect_word(r, wlen, n, i2s));
      qt.push_back(tag);
      send_half(lvl, l, wlen, n, i2s);
      send_half(!lvl, r, wlen, n, i2s);
    end
    bit_out(lvl, 1'b0);
    repeat (30) @(negedge clk);
    checks++;
    if (ql.size() != 0) begin
      errors++;
      $display("FAIL R9 %s missing pairs: actual %0d pending expected 0", tag, ql.size());
      ql.delete(); qr.delete(); qt.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (left_word !== 24'h0 || right_word !== 24'h0 || pair_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual l=%h r=%h v=%b expected 0 0 0", left_word, right_word, pair_valid);
    end
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    checks++;
    if (left_word !== 24'h0 || pair_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle after reset: actual l=%h v=%b expected 0 0", left_word, pair_valid);
    end

    run_case("R2 R4 rj24 padded",     0, 2'b00, 0, 2'b10, 0, 24, 32, 3);
    run_case("R4 R8 rj20",            0, 2'b00, 0, 2'b01, 0, 20, 24, 3);
    run_case("R4 R8 rj18",            0, 2'b00, 0, 2'b11, 0, 18, 24, 3);
    run_case("R4 R8 rj16",            0, 2'b00, 0, 2'b00, 0, 16, 24, 3);
    run_case("R7 packed16 over 24",   0, 2'b00, 0, 2'b10, 0, 16, 16, 3);
    run_case("R7 packed16 over 20",   0, 2'b00, 0, 2'b01, 0, 16, 16, 2);
    run_case("R3 i2s24 tail ignored", 0, 2'b00, 1, 2'b00, 0, 24, 32, 3);
    run_case("R3 R8 i2s16",           0, 2'b00, 1, 2'b10, 0, 16, 32, 3);
    run_case("R3 i2s truncated",      0, 2'b00, 1, 2'b00, 0, 24, 20, 3);
    run_case("R6 swapped rj24",       0, 2'b00, 0, 2'b10, 1, 24, 32, 3);
    run_case("R6 swapped i2s",        0, 2'b00, 1, 2'b00, 1, 24, 32, 2);
    run_case("R5 hw 00 rj16",         1, 2'b00, 1, 2'b11, 1, 16, 24, 3);
    run_case("R5 hw 01 rj20",         1, 2'b01, 1, 2'b00, 1, 20, 24, 3);
    run_case("R5 hw 10 rj24",         1, 2'b10, 1, 2'b01, 1, 24, 32, 3);
    run_case("R5 hw 11 i2s",          1, 2'b11, 0, 2'b00, 1, 24, 32, 3);
    finish_run();
  end
endmodule